// File: doc/BRIEF.md
# Qualified Input Count Gate

This block is a combinational voting gate. It counts how many of its `N` binary inputs are at logic 1 and compares that count with a threshold supplied at run time. A mode input picks one of six relations for the comparison: at least, more than, at most, fewer than, exactly, or other than. The result is one binary output. A single instance can therefore act as an AND, an OR, a majority gate, a k-of-N vote or an exclusion check, and it can switch between these without being rebuilt.

The block has no clock and holds no state. The output depends only on the present values of the inputs, the threshold and the mode. `N` is a parameter and may be set from 2 to 16. The threshold port is just wide enough to hold the value `N`.

Top module: `qual_count_gate`

## Requirements
- R1: Mode code 0 (at least): `out_o` is 1 exactly when the number of 1 bits on `in_i` is greater than or equal to `thresh_i`.
- R2: Mode code 1 (more than): `out_o` is 1 exactly when the count is strictly greater than `thresh_i`.
- R3: Mode code 2 (at most): `out_o` is 1 exactly when the count is less than or equal to `thresh_i`.
- R4: Mode code 3 (fewer than): `out_o` is 1 exactly when the count is strictly less than `thresh_i`. For example, with N=3 and threshold 2, mode 0 gives 1 for two or three true inputs and mode 3 gives 1 for zero or one.
- R5: Mode code 4 (exactly): `out_o` is 1 only when the count equals `thresh_i`.
- R6: Mode code 5 (other than): `out_o` is 1 whenever the count differs from `thresh_i`.
- R7: Mode codes 6 and 7 are reserved, and `out_o` is 0 for every input and threshold value.
- R8: `thresh_i` is `$clog2(N+1)` bits wide. A threshold above `N` is compared as a plain unsigned number with no clamping. Modes 0, 1 and 4 then give 0, and modes 2, 3 and 5 give 1.
- R9: The block is purely combinational. `out_o` follows a change on any input within the same time step, with no clock and no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_i | input | N | Binary vote inputs, 1 = true |
| thresh_i | input | $clog2(N+1) | Unsigned count threshold |
| mode_i | input | 3 | Relation select: 0 at least, 1 more than, 2 at most, 3 fewer than, 4 exactly, 5 other than, 6 and 7 reserved |
| out_o | output | 1 | Comparison result, 1 = true |

## Verification
The bench builds two instances. The first uses N=3, where the 2-bit threshold tops out at N itself. It is swept over every input pattern, every threshold and all eight mode codes, which includes the three-input example quoted in R4. The second uses N=16, where the 5-bit threshold can reach 31. It is driven with patterns of every population from 0 to 16, scattered across the bit positions, and checked against every threshold and mode. This brings the thresholds above N from R8 and the widest count chain within reach.

// File: rtl/qcg_pkg.sv
package qcg_pkg;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned NUM_REL = 6;

  localparam logic [MODE_W-1:0] MODE_GE = 3'd0;
  localparam logic [MODE_W-1:0] MODE_GT = 3'd1;
  localparam logic [MODE_W-1:0] MODE_LE = 3'd2;
  localparam logic [MODE_W-1:0] MODE_LT = 3'd3;
  localparam logic [MODE_W-1:0] MODE_EQ = 3'd4;
  localparam logic [MODE_W-1:0] MODE_NE = 3'd5;

  // bit positions inside the relation vector
  localparam int unsigned REL_GE = 0;
  localparam int unsigned REL_GT = 1;
  localparam int unsigned REL_LE = 2;
  localparam int unsigned REL_LT = 3;
  localparam int unsigned REL_EQ = 4;
  localparam int unsigned REL_NE = 5;
endpackage

// File: rtl/qcg_popcount.sv
module qcg_popcount #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  in_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] part [N+1];

  assign part[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_acc
    assign part[g+1] = part[g] + {{(CW-1){1'b0}}, in_i[g]};
  end

  assign cnt_o = part[N];

  always_comb begin
    p_cnt_ones_r9: assert (32'(cnt_o) == $countones(in_i))
      else $error("popcount disagrees with input population");
  end
endmodule

// File: rtl/qcg_relate.sv
module qcg_relate
  import qcg_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]       cnt_i,
  input  logic [W-1:0]       thr_i,
  output logic [NUM_REL-1:0] rel_o
);
  always_comb begin
    rel_o         = '0;
    rel_o[REL_GE] = (cnt_i >= thr_i);
    rel_o[REL_GT] = (cnt_i >  thr_i);
    rel_o[REL_LE] = (cnt_i <= thr_i);
    rel_o[REL_LT] = (cnt_i <  thr_i);
    rel_o[REL_EQ] = (cnt_i == thr_i);
    rel_o[REL_NE] = (cnt_i != thr_i);
  end

  always_comb begin
    p_ge_lt_split_r4: assert (rel_o[REL_GE] != rel_o[REL_LT])
      else $error("at-least and fewer-than both equal");
    p_gt_le_split_r2: assert (rel_o[REL_GT] != rel_o[REL_LE])
      else $error("more-than and at-most both equal");
    p_eq_ne_split_r6: assert (rel_o[REL_EQ] != rel_o[REL_NE])
      else $error("exactly and other-than both equal");
  end
endmodule

// File: rtl/qual_count_gate.sv
module qual_count_gate
  import qcg_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned TW = $clog2(N + 1)
) (
  input  logic [N-1:0]      in_i,
  input  logic [TW-1:0]     thresh_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              out_o
);
  logic [TW-1:0]      cnt;
  logic [NUM_REL-1:0] rel;

  qcg_popcount #(.N(N), .CW(TW)) u_count (
    .in_i  (in_i),
    .cnt_o (cnt)
  );

  qcg_relate #(.W(TW)) u_relate (
    .cnt_i (cnt),
    .thr_i (thresh_i),
    .rel_o (rel)
  );

  always_comb begin
    unique case (mode_i)
      MODE_GE: out_o = rel[REL_GE];
      MODE_GT: out_o = rel[REL_GT];
      MODE_LE: out_o = rel[REL_LE];
      MODE_LT: out_o = rel[REL_LT];
      MODE_EQ: out_o = rel[REL_EQ];
      MODE_NE: out_o = rel[REL_NE];
      default: out_o = 1'b0;
    endcase
  end

  always_comb begin
    p_reserved_zero_r7: assert (!(mode_i > MODE_NE && out_o))
      else $error("reserved mode drove output high");
    p_eq_exact_r5: assert (!(mode_i == MODE_EQ && out_o) ||
                           $countones(in_i) == 32'(thresh_i))
      else $error("exactly-mode high with wrong count");
    p_over_range_r8: assert (!(32'(thresh_i) > N && mode_i == MODE_GE && out_o))
      else $error("threshold above N satisfied at-least");
  end
endmodule

// File: tb/qual_count_gate_bench.sv
module qual_count_gate_bench;
  localparam int unsigned NA  = 3;
  localparam int unsigned TWA = $clog2(NA + 1);
  localparam int unsigned NB  = 16;
  localparam int unsigned TWB = $clog2(NB + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NA-1:0]  a_in;
  logic [TWA-1:0] a_thr;
  logic [2:0]     a_mode;
  logic           a_out;
  logic [NB-1:0]  b_in;
  logic [TWB-1:0] b_thr;
  logic [2:0]     b_mode;
  logic           b_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  qual_count_gate #(.N(NA)) u_qual_count_gate (
    .in_i(a_in), .thresh_i(a_thr), .mode_i(a_mode), .out_o(a_out));
  qual_count_gate #(.N(NB)) u_qual_count_gate_w (
    .in_i(b_in), .thresh_i(b_thr), .mode_i(b_mode), .out_o(b_out));

  function automatic bit model(int cnt, int thr, int mode);
    case (mode)
      0: return cnt >= thr;
      1: return cnt >  thr;
      2: return cnt <= thr;
      3: return cnt <  thr;
      4: return cnt == thr;
      5: return cnt != thr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag(int mode, int thr, int n);
    if (thr > n && mode < 6) return "R8";
    case (mode)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int ones(logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(bit act, bit exp, string t, int n, int pat, int thr, int mode);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s N=%0d in=%0h thr=%0d mode=%0d actual=%0b expected=%0b",
               t, n, pat, thr, mode, act, exp);
    end
  endtask

  initial begin
    a_in = '0; a_thr = '0; a_mode = '0;
    b_in = '0; b_thr = '0; b_mode = '0;
    // idle state: no inputs true, threshold 0, at-least mode -> 1 (R1)
    @(negedge clk); #2;
    check(a_out, 1'b1, "R1", NA, 0, 0, 0);

    // full sweep N=3; result checked two time units after drive (R9)
    for (int m = 0; m < 8; m++)
      for (int t = 0; t < (1 << TWA); t++)
        for (int p = 0; p < (1 << NA); p++) begin
          @(negedge clk);
          a_in = NA'(p); a_thr = TWA'(t); a_mode = 3'(m);
          #2;
          check(a_out, model(ones(32'(p)), t, m), tag(m, t, NA), NA, p, t, m);
        end

    // N=16: every population, scattered bit positions
    for (int m = 0; m < 8; m++)
      for (int t = 0; t < (1 << TWB); t++)
        for (int k = 0; k <= int'(NB); k++) begin
          logic [NB-1:0] base;
          logic [NB-1:0] pat;
          base = (k == int'(NB)) ? '1 : NB'((32'd1 << k) - 1);
          pat  = (base << ((k * 3) % NB)) | (base >> ((NB - (k * 3) % NB) % NB));
          @(negedge clk);
          b_in = pat; b_thr = TWB'(t); b_mode = 3'(m);
          #2;
          check(b_out, model(ones(32'(pat)), t, m), tag(m, t, NB), NB, int'(pat), t, m);
        end

    // R9: change only inputs mid-phase, no edge in between
    @(negedge clk);
    a_mode = 3'd0; a_thr = 2'd2; a_in = 3'b011; #1;
    check(a_out, 1'b1, "R9", NA, 3, 2, 0);
    a_in = 3'b001; #1;
    check(a_out, 1'b0, "R9", NA, 1, 2, 0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule